// File: doc/BRIEF.md
# Bidirectional Saturating Word Shifter

This block shifts a 32-bit signed word for a DSP-style execution pipe. One operation shifts left by a 5-bit count and clamps any result that does not fit in a signed 32-bit word. Another operation reads a 6-bit signed count. A count of zero or more shifts left with the same clamping. A negative count shifts right arithmetically by its magnitude. A third operation behaves like the second, except that a right shift is rounded half-up. A fourth op code is reserved and passes the word through unchanged.

The result is computed combinationally. It is captured into an output register on the clock edge at which the valid strobe is high, and it is presented sign-extended from bit 31 to the configured register width. Every left shift that clamps sets a sticky overflow flag. The flag stays set until reset, or until the clear input is sampled high while no clamping operation is captured on the same edge. Instruction decode and the register file live outside the block.

Top module: `sat_shift_unit`

## Requirements
- R1: When rst_n is sampled low at a rising edge, result_o and ovf_o are both 0 after that edge.
- R2: result_o changes only at a rising edge where valid_i is 1. At every other edge it holds its value, while ovf_o can still be cleared.
- R3: With op_i = 2'b00, the word is shifted left by amt_i[4:0]. Bits amt_i[31:5] have no effect.
- R4: A left shift is evaluated at full precision. A result above 0x7FFFFFFF becomes 0x7FFFFFFF, a result below -2^31 becomes 0x80000000, and either case sets ovf_o at the capture edge.
- R5: With op_i = 2'b01, amt_i[5:0] is read as a signed count from -32 to 31, and bits amt_i[31:6] have no effect. A count of zero or more performs the saturating left shift of R4.
- R6: A negative count shifts right arithmetically by its magnitude, and a magnitude of 32 is treated as 31. A right shift never sets ovf_o.
- R7: With op_i = 2'b10, the count is read as in R5. A right shift by m gives ((x >>> (m-1)) + 1) >>> 1 with no wrap, where x is the signed input and m is clamped to 31 as in R6. A left shift saturates as in R4.
- R8: op_i = 2'b11 passes data_i through. An effective shift count of 0 in any mode also returns the input. Neither case changes ovf_o.
- R9: ovf_o is sticky. It stays 1 until an edge where ovf_clr_i is 1 and no saturating operation is captured, and setting takes priority over clearing on the same edge.
- R10: result_o[XLEN-1:32] all equal result_o[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Capture strobe for the current operation |
| op_i | input | 2 | Operation: 00 left, 01 signed count, 10 signed count with rounding, 11 pass |
| data_i | input | 32 | Word to shift |
| amt_i | input | 32 | Shift count operand; only its low bits are used |
| ovf_clr_i | input | 1 | Clears the sticky overflow flag |
| result_o | output | XLEN | Registered result, sign-extended from bit 31 |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Both the result and the flag update at the same rising edge that samples valid_i high, so each is due one edge after the stimulus is applied. The bench applies inputs on a falling edge. It advances a behavioural model at the next rising edge, and it compares result_o and ovf_o with the model at the falling edge that follows. This keeps every comparison half a cycle away from any edge at which the outputs move. The directed cases cover the exact clamp boundaries, the -32 count, rounding of negative values, and a clear that arrives on the same edge as a set. A long randomised run then exercises every op code under the same comparison.

// File: rtl/sshift_pkg.sv
// Shared types for the bidirectional saturating shifter.
// Assumes a 32-bit data word. The register width is chosen by the top module.
package sshift_pkg;
    localparam int WORD_W = 32;
    localparam int SA_W   = $clog2(WORD_W);
    localparam int CNT_W  = SA_W + 1;

    typedef enum logic [1:0] {
        OP_LSAT    = 2'b00,
        OP_BIDIR   = 2'b01,
        OP_BIDIR_R = 2'b10,
        OP_PASS    = 2'b11
    } shift_op_e;

    typedef struct packed {
        logic            go_right;
        logic            is_zero;
        logic [SA_W-1:0] mag;
    } shamt_t;
endpackage

// File: rtl/sshift_amt_dec.sv
// Turns the op code and the low count bits into a direction and a magnitude.
// Assumes cnt_i holds the low CNT_W bits of the count operand. For the
// signed modes, a magnitude of 2^SA_W is clamped to 2^SA_W - 1.
module sshift_amt_dec
    import sshift_pkg::*;
(
    input  shift_op_e        op_i,
    input  logic [CNT_W-1:0] cnt_i,
    output shamt_t           dec_o
);
    logic [CNT_W-1:0] neg_mag;

    // Negate the two's complement count to get the right-shift magnitude.
    always_comb neg_mag = (~cnt_i) + CNT_W'(1);

    // Pick the direction and magnitude for each op code.
    always_comb begin
        dec_o = '0;
        unique case (op_i)
            OP_LSAT: dec_o.mag = cnt_i[SA_W-1:0];
            OP_BIDIR, OP_BIDIR_R: begin
                if (cnt_i[CNT_W-1]) begin
                    dec_o.go_right = 1'b1;
                    dec_o.mag = neg_mag[CNT_W-1] ? {SA_W{1'b1}} : neg_mag[SA_W-1:0];
                end else begin
                    dec_o.mag = cnt_i[SA_W-1:0];
                end
            end
            default: dec_o.mag = '0;
        endcase
        dec_o.is_zero = (dec_o.mag == '0);
    end
endmodule

// File: rtl/sshift_lsat.sv
// Left shift at full precision, clamped to the signed W-bit range.
// Assumes sa_i < W. sat_o is set when the exact value does not fit.
module sshift_lsat #(
    parameter int W    = 32,
    parameter int SA_W = $clog2(W)
) (
    input  logic [W-1:0]    din_i,
    input  logic [SA_W-1:0] sa_i,
    output logic [W-1:0]    dout_o,
    output logic            sat_o
);
    localparam int WIDE_W = 2 * W;

    logic [WIDE_W-1:0] wide;
    logic [W:0]        upper;

    // Sign-extend the word to double width and shift it without losing bits.
    always_comb wide = {{W{din_i[W-1]}}, din_i} << sa_i;

    // Detect overflow: everything from bit W-1 upward must be one repeated sign bit.
    always_comb begin
        upper = wide[WIDE_W-1:W-1];
        sat_o = !((&upper) || !(|upper));
    end

    // Clamp toward the sign of the input when the shift overflows.
    always_comb begin
        if (!sat_o)          dout_o = wide[W-1:0];
        else if (din_i[W-1]) dout_o = {1'b1, {(W-1){1'b0}}};
        else                 dout_o = {1'b0, {(W-1){1'b1}}};
    end
endmodule

// File: rtl/sshift_rsh.sv
// Arithmetic right shift, optionally rounded half-up.
// Assumes sa_i is at least 1. The word is widened by one bit, so the
// rounding increment cannot wrap.
module sshift_rsh #(
    parameter int W    = 32,
    parameter int SA_W = $clog2(W)
) (
    input  logic [W-1:0]    din_i,
    input  logic [SA_W-1:0] sa_i,
    input  logic            round_i,
    output logic [W-1:0]    dout_o
);
    logic signed [W:0] ext;
    logic signed [W:0] plain;
    logic signed [W:0] part;
    logic signed [W:0] bumped;
    logic signed [W:0] rounded;
    logic [SA_W-1:0]   sa_m1;

    // Widen the operand by one sign bit.
    always_comb ext = $signed({din_i[W-1], din_i});

    // Truncating arithmetic shift.
    always_comb plain = ext >>> sa_i;

    // Rounding: stop one bit short, add one at the last discarded bit, then drop it.
    always_comb begin
        sa_m1   = (sa_i == '0) ? '0 : sa_i - SA_W'(1);
        part    = ext >>> sa_m1;
        bumped  = part + (W+1)'(1);
        rounded = bumped >>> 1;
    end

    // Pick the truncating or the rounded form.
    always_comb dout_o = round_i ? rounded[W-1:0] : plain[W-1:0];
endmodule

// File: rtl/sat_shift_unit.sv
// Top of the bidirectional saturating shifter. The word result is computed
// combinationally and captured when valid_i is high. The sticky overflow
// flag is set by a clamping left shift and cleared by ovf_clr_i, with set
// taking priority. Assumes XLEN >= 32. Synchronous active-low reset.
module sat_shift_unit
    import sshift_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [1:0]      op_i,
    input  logic [31:0]     data_i,
    input  logic [31:0]     amt_i,
    input  logic            ovf_clr_i,
    output logic [XLEN-1:0] result_o,
    output logic            ovf_o
);
    shift_op_e          op;
    shamt_t             dec;
    logic [WORD_W-1:0]  lsat_word;
    logic               lsat_hit;
    logic [WORD_W-1:0]  rsh_word;
    logic [WORD_W-1:0]  word_next;
    logic               word_sat;
    logic [WORD_W-1:0]  res_q;
    logic               ovf_q;
    logic               unused_amt;

    // Convert the raw op bits into the enumerated op.
    always_comb op = shift_op_e'(op_i);

    // Count bits above the signed field are ignored by definition.
    always_comb unused_amt = ^amt_i[WORD_W-1:CNT_W];

    sshift_amt_dec u_dec (
        .op_i  (op),
        .cnt_i (amt_i[CNT_W-1:0]),
        .dec_o (dec)
    );

    sshift_lsat #(.W(WORD_W), .SA_W(SA_W)) u_lsat (
        .din_i  (data_i),
        .sa_i   (dec.mag),
        .dout_o (lsat_word),
        .sat_o  (lsat_hit)
    );

    sshift_rsh #(.W(WORD_W), .SA_W(SA_W)) u_rsh (
        .din_i   (data_i),
        .sa_i    (dec.mag),
        .round_i (op == OP_BIDIR_R),
        .dout_o  (rsh_word)
    );

    // Select the word result and whether it clamped.
    always_comb begin
        word_next = data_i;
        word_sat  = 1'b0;
        if (op != OP_PASS && !dec.is_zero) begin
            if (dec.go_right) begin
                word_next = rsh_word;
            end else begin
                word_next = lsat_word;
                word_sat  = lsat_hit;
            end
        end
    end

    // Result register: load on the strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= '0;
        else if (valid_i) res_q <= word_next;
    end

    // Sticky flag: a captured clamp sets it, the clear input resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ovf_q <= 1'b0;
        else if (valid_i && word_sat) ovf_q <= 1'b1;
        else if (ovf_clr_i)          ovf_q <= 1'b0;
    end

    // Sign-extend the word to the register width.
    generate
        if (XLEN > WORD_W) begin : g_sext
            assign result_o = {{(XLEN-WORD_W){res_q[WORD_W-1]}}, res_q};
        end else begin : g_flat
            assign result_o = res_q[XLEN-1:0];
        end
    endgenerate

    assign ovf_o = ovf_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (res_q == '0 && !ovf_q));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(res_q));

    // R4
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && word_sat) |=> ((res_q == 32'h7FFF_FFFF || res_q == 32'h8000_0000) && ovf_q));

    // R6
    right_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op != OP_PASS && dec.go_right && !ovf_q) |=> !ovf_q);

    // R8
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 2'b11) |=> (res_q == $past(data_i) && ovf_q == $past(ovf_q && !ovf_clr_i)));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr_i) |=> ovf_q);
endmodule

// File: tb/sat_shift_unit_tb.sv
`timescale 1ns/1ps
module sat_shift_unit_tb_top;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            valid_i = 1'b0;
    logic [1:0]      op_i = 2'b00;
    logic [31:0]     data_i = '0;
    logic [31:0]     amt_i = '0;
    logic            ovf_clr_i = 1'b0;
    logic [XLEN-1:0] result_o;
    logic            ovf_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    armed = 1'b0;
    logic [31:0] exp_word = '0;
    bit    exp_ovf = 1'b0;
    string exp_tag = "R1";

    always #5 clk = ~clk;

    sat_shift_unit #(.XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
        .data_i(data_i), .amt_i(amt_i), .ovf_clr_i(ovf_clr_i),
        .result_o(result_o), .ovf_o(ovf_o)
    );

    function automatic void left_ref(input logic [31:0] d, input int sa,
                                     output logic [31:0] r, output bit s);
        longint v;
        v = longint'($signed(d)) <<< sa;
        s = 1'b1;
        if (v > 64'sd2147483647)       r = 32'h7FFF_FFFF;
        else if (v < -64'sd2147483648) r = 32'h8000_0000;
        else begin r = v[31:0]; s = 1'b0; end
    endfunction

    // Behavioural reference for one captured operation.
    function automatic void model(input logic [1:0] op, input logic [31:0] d,
                                  input logic [31:0] a, output logic [31:0] r,
                                  output bit s, output string tag);
        int c;
        int m;
        longint x;
        s = 1'b0;
        r = d;
        x = longint'($signed(d));
        if (op == 2'b11) begin
            tag = "R8";
        end else if (op == 2'b00) begin
            left_ref(d, int'(a[4:0]), r, s);
            tag = (a[4:0] == 0) ? "R8" : (s ? "R4" : "R3");
        end else begin
            c = a[5] ? int'(a[5:0]) - 64 : int'(a[5:0]);
            if (c >= 0) begin
                left_ref(d, c, r, s);
                tag = (c == 0) ? "R8" : (s ? "R4" : "R5");
            end else begin
                m = -c;
                if (m == 32) m = 31;
                if (op == 2'b01) begin
                    x = x >>> m;
                    tag = "R6";
                end else begin
                    x = ((x >>> (m - 1)) + 1) >>> 1;
                    tag = "R7";
                end
                r = x[31:0];
            end
        end
    endfunction

    // Advance the reference model at every rising edge.
    always @(posedge clk) begin
        logic [31:0] r;
        bit s;
        string t;
        if (!rst_n) begin
            exp_word = '0;
            exp_ovf  = 1'b0;
            exp_tag  = "R1";
        end else if (valid_i) begin
            model(op_i, data_i, amt_i, r, s, t);
            exp_word = r;
            exp_tag  = t;
            if (s) exp_ovf = 1'b1;
            else if (ovf_clr_i) exp_ovf = 1'b0;
        end else begin
            exp_tag = "R2";
            if (ovf_clr_i) exp_ovf = 1'b0;
        end
        armed = 1'b1;
    end

    // Compare outputs with the model at each falling edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            checks++;
            if (result_o[31:0] !== exp_word) begin
                errors++;
                $display("FAIL %s: result %h expected %h", exp_tag, result_o[31:0], exp_word);
            end
            checks++;
            if (result_o[XLEN-1:32] !== {(XLEN-32){exp_word[31]}}) begin
                errors++;
                $display("FAIL R10: upper %h expected %h", result_o[XLEN-1:32], {(XLEN-32){exp_word[31]}});
            end
            checks++;
            if (ovf_o !== exp_ovf) begin
                errors++;
                $display("FAIL R9 (%s): ovf %0b expected %0b", exp_tag, ovf_o, exp_ovf);
            end
        end
    end

    task automatic drive(input bit v, input logic [1:0] op, input logic [31:0] d,
                         input logic [31:0] a, input bit clr);
        @(negedge clk);
        valid_i = v; op_i = op; data_i = d; amt_i = a; ovf_clr_i = clr;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);        // R1 reset state compared here
        drive(0, 2'b00, 0, 0, 0);
        rst_n = 1'b1;
        drive(1, 2'b00, 32'd1, 32'd5, 0);              // R3: 1<<5
        drive(1, 2'b00, 32'd3, 32'hFFFF_FFE3, 0);      // R3: upper count bits ignored
        drive(1, 2'b00, 32'h4000_0000, 32'd1, 0);      // R4: clamp high
        drive(0, 2'b01, 32'h1234_5678, 32'd4, 0);      // R2: hold
        drive(0, 2'b00, 0, 0, 1);                      // R9: clear
        drive(1, 2'b00, 32'hC000_0000, 32'd1, 0);      // R4: exact min, no clamp
        drive(1, 2'b00, 32'hC000_0000, 32'd2, 0);      // R4: clamp low
        drive(1, 2'b10, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0); // R9: flag stays
        drive(1, 2'b00, 32'h7000_0000, 32'd4, 1);      // R9: set beats clear
        drive(0, 2'b00, 0, 0, 1);
        drive(1, 2'b01, 32'h8000_0001, 32'h0000_003F, 0); // R6: -1
        drive(1, 2'b01, 32'h8000_0000, 32'h0000_0020, 0); // R6: -32 clamps to 31
        drive(1, 2'b01, 32'h0000_0005, 32'hABCD_EF03, 0); // R5: +3, upper bits ignored
        drive(1, 2'b01, 32'h2000_0000, 32'h0000_0002, 0); // R5/R4 clamp
        drive(0, 2'b00, 0, 0, 1);
        drive(1, 2'b10, 32'd3, 32'h0000_003F, 0);      // R7: 2
        drive(1, 2'b10, 32'hFFFF_FFFD, 32'h0000_003F, 0); // R7: -1
        drive(1, 2'b10, 32'h4000_0000, 32'h0000_0020, 0); // R7: -32 -> 1
        drive(1, 2'b10, 32'h7FFF_FFFF, 32'h0000_003F, 0); // R7: no wrap
        drive(1, 2'b11, 32'hDEAD_BEEF, 32'd7, 0);      // R8 and R10
        drive(1, 2'b01, 32'h8765_4321, 32'hFFFF_FFC0, 0); // R8: zero count
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            a = $urandom;
            if (i % 4 == 0) a[31:6] = '0;
            drive(($urandom % 4) != 0, 2'($urandom), $urandom, a, ($urandom % 8) == 0);
        end
        rst_n = 1'b0;
        drive(1, 2'b00, 32'h4000_0000, 32'd1, 0);      // R1: reset dominates
        drive(0, 2'b00, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule